// File: doc/BRIEF.md
# Tracking Error Offset Capture

This block learns the slow offset that disc eccentricity puts on a tracking-error sample stream and then removes it from two error channels. While the measure control is high, each valid tracking-error sample feeds a first-order exponential averager. The averager's output is copied into a held offset register on every cycle of the measurement. When measuring stops, the register keeps its last value.

With the compensate control high, the held offset is subtracted from both the tracking-error channel and the sled-error channel, and each result is clamped to the signed output range. With compensation off, both channels pass through unchanged. Both channels always go through one output register, so latency is the same in either mode.

Top module: `te_offset_comp`

## Requirements
- R1: The averager state A (W+K bits, scaled by 2^K) changes only on a clock edge where measure is high and the tracking-error valid is high. It then becomes A + x - (A >>> K), where x is the sign-extended sample. The averager output is A >>> K (floor).
- R2: On every clock edge with measure high, the offset register loads the averager output as it stands after that edge.
- R3: On every clock edge with measure low, the offset register keeps its value. This includes the edge right after measure falls.
- R4: With compensate high on an edge, the outputs te_o and se_o become te_i minus offset and se_i minus offset. The offset used is the one held before that edge.
- R5: The subtraction saturates to the range -2^(W-1) to 2^(W-1)-1 (-512 to 511 at W=10) and never wraps.
- R6: With compensate low on an edge, te_o and se_o become te_i and se_i unchanged, one cycle later.
- R7: Reset (rst_n low, asynchronous) clears the averager state, the offset register and the outputs to zero.
- R8: te_vld_o and se_vld_o equal te_vld_i and se_vld_i delayed by one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| meas_en_i | input | 1 | Measure control: average TE and load the offset |
| comp_en_i | input | 1 | Compensate control: subtract the held offset |
| te_i | input | W | Tracking-error sample, two's complement |
| te_vld_i | input | 1 | Tracking-error sample valid |
| se_i | input | W | Sled-error sample, two's complement |
| se_vld_i | input | 1 | Sled-error sample valid |
| te_o | output | W | Compensated tracking error |
| te_vld_o | output | 1 | Delayed tracking-error valid |
| se_o | output | W | Compensated sled error |
| se_vld_o | output | 1 | Delayed sled-error valid |

## Verification
The assertions assume that the control and data inputs are stable and known at each rising edge. They also assume that measure and compensate may be high at the same time. The bench drives every input one time unit after the rising edge from a fixed-seed $urandom stream, so inputs never move at an edge. Random phases mix measuring, frozen, compensating and pass-through states, with random valid strobes. Directed phases pin the offset near both range limits, so that the saturation in both directions is reached.

// File: rtl/teoc_pkg.sv
package teoc_pkg;
   localparam int NUM_CH = 2;
   typedef enum int {CH_TE = 0, CH_SE = 1} teoc_ch_e;
endpackage

// File: rtl/teoc_lpf.sv
module teoc_lpf #(
   parameter int W = 10,
   parameter int K = 6
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                upd_i,
   input  logic signed [W-1:0] x_i,
   output logic signed [W-1:0] y_next_o
);
   localparam int AW = W + K;

   logic signed [AW-1:0] acc_q;
   logic signed [AW-1:0] shr;
   logic signed [AW:0]   sum;
   logic signed [AW-1:0] acc_nxt;
   logic signed [W-1:0]  y_cur;

   always_comb begin
      shr     = acc_q >>> K;
      sum     = {acc_q[AW-1], acc_q} + {{(K + 1){x_i[W-1]}}, x_i} - {shr[AW-1], shr};
      acc_nxt = sum[AW-1:0];
      y_cur   = acc_q[AW-1:K];
      y_next_o = upd_i ? acc_nxt[AW-1:K] : y_cur;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     acc_q <= '0;
      else if (upd_i) acc_q <= acc_nxt;
   end

   assert_lpf_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !upd_i |=> $stable(acc_q));
endmodule

// File: rtl/teoc_hold.sv
module teoc_hold #(
   parameter int W = 10
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                load_i,
   input  logic signed [W-1:0] d_i,
   output logic signed [W-1:0] q_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q_o <= '0;
      else if (load_i) q_o <= d_i;
   end

   assert_offset_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> q_o == $past(d_i));
   assert_offset_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !load_i |=> $stable(q_o));
endmodule

// File: rtl/teoc_sat_sub.sv
module teoc_sat_sub #(
   parameter int W = 10
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                comp_i,
   input  logic signed [W-1:0] a_i,
   input  logic                vld_i,
   input  logic signed [W-1:0] b_i,
   output logic signed [W-1:0] y_o,
   output logic                vld_o
);
   localparam logic signed [W-1:0] MAXV = {1'b0, {(W - 1){1'b1}}};
   localparam logic signed [W-1:0] MINV = {1'b1, {(W - 1){1'b0}}};

   logic signed [W:0]   diff;
   logic signed [W-1:0] clamped;
   logic signed [W-1:0] res;

   always_comb begin
      diff = {a_i[W-1], a_i} - {b_i[W-1], b_i};
      if (diff[W] != diff[W-1]) clamped = diff[W] ? MINV : MAXV;
      else                      clamped = diff[W-1:0];
      res = comp_i ? clamped : a_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         y_o   <= '0;
         vld_o <= 1'b0;
      end else begin
         y_o   <= res;
         vld_o <= vld_i;
      end
   end

   assert_no_wrap_pos_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (comp_i && !a_i[W-1] && b_i[W-1]) |=> !y_o[W-1]);
   assert_no_wrap_neg_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (comp_i && a_i[W-1] && !b_i[W-1]) |=> y_o[W-1]);
   assert_passthru_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !comp_i |=> y_o == $past(a_i));
   assert_valid_delay_R8: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> vld_o == $past(vld_i));
endmodule

// File: rtl/te_offset_comp.sv
module te_offset_comp #(
   parameter int W = 10,
   parameter int K = 6
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                meas_en_i,
   input  logic                comp_en_i,
   input  logic signed [W-1:0] te_i,
   input  logic                te_vld_i,
   input  logic signed [W-1:0] se_i,
   input  logic                se_vld_i,
   output logic signed [W-1:0] te_o,
   output logic                te_vld_o,
   output logic signed [W-1:0] se_o,
   output logic                se_vld_o
);
   import teoc_pkg::*;

   generate
      if (W < 2 || W > 32) begin : g_bad_w
         $error("te_offset_comp: W must lie in 2..32");
      end
      if (K < 1 || K > 16) begin : g_bad_k
         $error("te_offset_comp: K must lie in 1..16");
      end
   endgenerate

   logic signed [W-1:0] y_next;
   logic signed [W-1:0] offset_q;
   logic                lpf_upd;

   logic signed [W-1:0] ch_in  [NUM_CH];
   logic                ch_vin [NUM_CH];
   logic signed [W-1:0] ch_out [NUM_CH];
   logic                ch_vout[NUM_CH];

   assign lpf_upd = meas_en_i & te_vld_i;

   teoc_lpf #(.W(W), .K(K)) u_lpf (
      .clk(clk), .rst_n(rst_n), .upd_i(lpf_upd), .x_i(te_i), .y_next_o(y_next)
   );

   teoc_hold #(.W(W)) u_hold (
      .clk(clk), .rst_n(rst_n), .load_i(meas_en_i), .d_i(y_next), .q_o(offset_q)
   );

   assign ch_in[CH_TE]  = te_i;
   assign ch_in[CH_SE]  = se_i;
   assign ch_vin[CH_TE] = te_vld_i;
   assign ch_vin[CH_SE] = se_vld_i;

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      teoc_sat_sub #(.W(W)) u_sub (
         .clk(clk), .rst_n(rst_n), .comp_i(comp_en_i),
         .a_i(ch_in[c]), .vld_i(ch_vin[c]), .b_i(offset_q),
         .y_o(ch_out[c]), .vld_o(ch_vout[c])
      );
   end

   assign te_o     = ch_out[CH_TE];
   assign se_o     = ch_out[CH_SE];
   assign te_vld_o = ch_vout[CH_TE];
   assign se_vld_o = ch_vout[CH_SE];

   assert_comp_both_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (comp_en_i && te_i == se_i) |=> te_o == se_o);
endmodule

// File: tb/sim_te_offset_comp.sv
module sim_te_offset_comp;
   localparam int W = 10;
   localparam int K = 6;
   localparam int MAXV = (1 << (W - 1)) - 1;
   localparam int MINV = -(1 << (W - 1));

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic meas_en, comp_en, te_vld, se_vld;
   logic signed [W-1:0] te_in, se_in, te_out, se_out;
   logic te_vld_out, se_vld_out;

   int checks = 0;
   int errors = 0;
   int acc_m = 0;
   int off_m = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   te_offset_comp #(.W(W), .K(K)) u0 (
      .clk(clk), .rst_n(rst_n), .meas_en_i(meas_en), .comp_en_i(comp_en),
      .te_i(te_in), .te_vld_i(te_vld), .se_i(se_in), .se_vld_i(se_vld),
      .te_o(te_out), .te_vld_o(te_vld_out), .se_o(se_out), .se_vld_o(se_vld_out)
   );

   function automatic int sat(input int v);
      if (v > MAXV) return MAXV;
      if (v < MINV) return MINV;
      return v;
   endfunction

   function automatic int lpf_step(input int a, input int x);
      return a + x - (a >>> K);
   endfunction

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic step(input bit m, input bit c, input int te, input bit tv,
                       input int se, input bit sv);
      int exp_te, exp_se, raw_te, raw_se;
      string rq;
      meas_en = m; comp_en = c; te_in = te[W-1:0]; se_in = se[W-1:0];
      te_vld = tv; se_vld = sv;
      raw_te = te - off_m;
      raw_se = se - off_m;
      exp_te = c ? sat(raw_te) : te;
      exp_se = c ? sat(raw_se) : se;
      if (!c) rq = "R6";
      else if (raw_te != exp_te || raw_se != exp_se) rq = "R5";
      else if (m && !tv) rq = "R1";
      else if (m) rq = "R2";
      else rq = "R3/R4";
      if (m && tv) acc_m = lpf_step(acc_m, te);
      if (m) off_m = acc_m >>> K;
      @(posedge clk);
      #1;
      check({rq, " te_o"}, int'(te_out), exp_te);
      check({rq, " se_o"}, int'(se_out), exp_se);
      check("R8 te_vld_o", int'(te_vld_out), int'(tv));
      check("R8 se_vld_o", int'(se_vld_out), int'(sv));
   endtask

   function automatic int rnd_val();
      return int'($urandom_range(2 * MAXV + 1)) + MINV;
   endfunction

   initial begin
      int seed_dummy;
      seed_dummy = int'($urandom(1234));
      meas_en = 0; comp_en = 0; te_in = '0; se_in = '0; te_vld = 0; se_vld = 0;
      repeat (3) @(posedge clk);
      #1;
      check("R7 te_o reset", int'(te_out), 0);
      check("R7 se_o reset", int'(se_out), 0);
      rst_n = 1'b1;
      // R7: offset starts at zero, so compensation leaves samples unchanged
      step(0, 1, 37, 1, -21, 1);
      step(0, 1, -300, 0, 250, 1);
      // R5: drive offset toward the negative limit, then push te to the top
      for (int i = 0; i < 800; i++) step(1, 0, MINV, 1, 0, 0);
      step(0, 1, MAXV, 1, MAXV, 1);
      step(0, 1, 0, 1, -5, 1);
      // R3: wild input with measure low must not move the offset
      for (int i = 0; i < 50; i++) step(0, 0, rnd_val(), 1, rnd_val(), 1);
      step(0, 1, 0, 1, 0, 1);
      // R5: offset toward the positive limit, then low inputs
      for (int i = 0; i < 800; i++) step(1, 1, MAXV, 1, MINV, 1);
      step(0, 1, MINV, 1, MINV, 1);
      // R1: measuring with no valid strobe keeps the averager still
      for (int i = 0; i < 20; i++) step(1, 1, MINV, 0, 0, 1);
      // random phases
      for (int ph = 0; ph < 40; ph++) begin
         bit m = 1'($urandom_range(1));
         bit c = 1'($urandom_range(1));
         int base = rnd_val() / 2;
         for (int i = 0; i < 100; i++)
            step(m, c, sat(base + int'($urandom_range(80)) - 40), 1'($urandom_range(1)),
                 rnd_val(), 1'($urandom_range(1)));
      end
      done = 1'b1;
   end

   initial begin
      for (int n = 0; n < 150000 && !done; n++) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
      end
      #2;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule